// File: doc/BRIEF.md
# Dual-Port Burst-of-Four Memory

This block is a synthesizable memory with one port that only reads and one that only writes. The ports share no data bus. Every access moves four 18-bit words. Each word is split into two 9-bit bytes. The block runs from a single clock at twice the transfer rate, so that one word moves per edge of that clock. A phase bit marks which edges are "main" edges. A request is taken only on a main edge. A port that accepted a request ignores a second request on its next main edge, because that edge falls inside the burst still in flight.

A write collects four words on the edges that follow the request. A per-byte select can skip any byte, and a skipped byte keeps its old contents. The assembled 72-bit burst then goes into the array in one step, through byte-wide lanes that map onto block RAM. A read fetches the whole 72-bit location once and sends it out one word per edge. A write that has been accepted but not yet stored is forwarded to the read byte by byte, so a read always returns the newest data. After the last word of a burst, the output-enable flag drops and the data output returns to zero.

Top module: `burst4_sram`

## Requirements
- R1: `kphase` is 0 during the cycle before every main edge and 1 before every other edge. It alternates on every clock, and the first edge after reset is a main edge.
- R2: While `rst` is high, `q_oe` is 0, `q` is 0 and `kphase` is 0.
- R3: When `rd_n` is low at a main edge t and the read is accepted, word k (k = 0..3) of the addressed burst is on `q` with `q_oe` high after edge t+2+k.
- R4: If a port accepted a request at main edge t, a request on the same port at main edge t+2 is ignored. This applies to both ports: an ignored read produces no burst, and an ignored write stores nothing.
- R5: When a write is accepted at main edge w, the value on `d` at edge w+2+k becomes word k of the burst at `wr_addr`. Reads issued later return that word.
- R6: The byte selects are sampled with each write word. `bw_n[0]` low enables `d[8:0]` and `bw_n[1]` low enables `d[17:9]`. A disabled byte keeps its previous contents.
- R7: A read accepted at main edge t returns the effect of every write accepted at a main edge before t, including one accepted at t-2, whose data is still arriving. A write accepted at the same edge t is not seen.
- R8: On every edge that carries no burst word, `q_oe` goes low and `q` goes to 0. This happens on the first edge after a burst's last word.
- R9: A low `rd_n` or `wr_n` at an edge where `kphase` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock. Every rising edge moves one data word. |
| rst | input | 1 | Synchronous reset, active high. |
| rd_n | input | 1 | Read request, active low, taken at main edges. |
| rd_addr | input | 8 | Burst address for the read. |
| wr_n | input | 1 | Write request, active low, taken at main edges. |
| wr_addr | input | 8 | Burst address for the write. |
| d | input | 18 | Write data word, sampled on every edge during a write burst. |
| bw_n | input | 2 | Byte write selects, active low: bit 0 for bits 8:0, bit 1 for bits 17:9. |
| q | output | 18 | Read data word, registered. Zero when idle. |
| q_oe | output | 1 | High while `q` carries a burst word. Stands in for the output's drive enable. |
| kphase | output | 1 | Phase of the next edge: 0 means the next edge is a main edge. |

## Verification
The hardest case to reach is a read whose target write is still in progress. The write can be accepted two or four cycles earlier, with some of its bytes masked off. The read must then mix forwarded bytes with old array bytes inside a single burst. To get there, the stimulus limits addresses to a few locations and issues reads and writes on nearly every main edge with random byte selects. The reference model applies each write word at the edge where it is captured. It evaluates each read word before that edge's capture, which also covers a read and a write to the same address accepted at the same edge.

// File: rtl/b4_pkg.sv
package b4_pkg;

  // Words per burst; the forwarding window in the top depends on this value.
  localparam int unsigned BEATS = 4;

  typedef enum logic {
    PH_MAIN = 1'b0,
    PH_ALT  = 1'b1
  } phase_e;

  function automatic int unsigned lane_idx(input int unsigned beat,
                                           input int unsigned byte_i,
                                           input int unsigned per_word);
    return beat * per_word + byte_i;
  endfunction

endpackage

// File: rtl/b4_lane_ram.sv
module b4_lane_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned BW    = 9,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [BW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [BW-1:0] rdata
);

  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/b4_wr_ctrl.sv
module b4_wr_ctrl
  import b4_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned WORD_W = 18,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned BPW   = WORD_W / BYTE_W,
  localparam int unsigned LANES = BEATS * BPW,
  localparam int unsigned SRW   = BEATS + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    main,
  input  logic                    req_n,
  input  logic [AW-1:0]           addr,
  input  logic [WORD_W-1:0]       din,
  input  logic [BPW-1:0]          be_n,
  output logic                    acc,
  output logic                    recent,
  output logic [AW-1:0]           last_addr,
  output logic [BEATS*WORD_W-1:0] wbuf,
  output logic [LANES-1:0]        wmask,
  output logic                    commit,
  output logic [AW-1:0]           commit_addr
);

  // age_sr[i] set at an edge means a write was accepted i+1 edges earlier
  logic [SRW-1:0] age_sr;

  assign acc    = main && !req_n && !age_sr[1];
  assign commit = age_sr[SRW-1];
  // writes accepted 2 or 4 edges ago have not reached the array by the read fetch
  assign recent = age_sr[1] | age_sr[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      age_sr <= '0;
    end else begin
      age_sr <= {age_sr[SRW-2:0], acc};
    end
  end

  always_ff @(posedge clk) begin
    if (acc) last_addr <= addr;
    if (age_sr[1]) commit_addr <= last_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wmask <= '0;
    end else begin
      for (int k = 0; k < BEATS; k++) begin
        if (age_sr[k+1]) begin
          wmask[k*BPW +: BPW] <= ~be_n;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < BEATS; k++) begin
      if (age_sr[k+1]) begin
        wbuf[k*WORD_W +: WORD_W] <= din;
      end
    end
  end

endmodule

// File: rtl/b4_rd_ctrl.sv
module b4_rd_ctrl
  import b4_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             main,
  input  logic             req_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_recent,
  input  logic [AW-1:0]    wr_last,
  output logic             acc,
  output logic             ram_re,
  output logic [AW-1:0]    ram_addr,
  output logic [BEATS-1:0] beat,
  output logic             fwd
);

  logic [BEATS:0] sr;
  logic           fwd_cap;

  assign acc    = main && !req_n && !sr[1];
  assign ram_re = sr[0];
  assign beat   = sr[BEATS:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      fwd_cap <= 1'b0;
      fwd     <= 1'b0;
    end else begin
      sr <= {sr[BEATS-1:0], acc};
      if (acc) fwd_cap <= wr_recent && (wr_last == addr);
      if (sr[0]) fwd <= fwd_cap;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) ram_addr <= addr;
  end

endmodule

// File: rtl/burst4_sram.sv
module burst4_sram
  import b4_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned WORD_W = 18,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned BPW   = WORD_W / BYTE_W,
  localparam int unsigned LANES = BEATS * BPW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_n,
  input  logic [AW-1:0]     rd_addr,
  input  logic              wr_n,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] d,
  input  logic [BPW-1:0]    bw_n,
  output logic [WORD_W-1:0] q,
  output logic              q_oe,
  output logic              kphase
);

  phase_e ph;
  logic   main;

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_MAIN;
    else     ph <= (ph == PH_MAIN) ? PH_ALT : PH_MAIN;
  end

  assign main   = (ph == PH_MAIN);
  assign kphase = (ph == PH_ALT);

  logic                    wr_acc, wr_recent, wr_commit;
  logic [AW-1:0]           wr_last, wr_caddr;
  logic [BEATS*WORD_W-1:0] wbuf;
  logic [LANES-1:0]        wmask;

  b4_wr_ctrl #(.AW(AW), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_wr (
    .clk(clk), .rst(rst), .main(main), .req_n(wr_n), .addr(wr_addr),
    .din(d), .be_n(bw_n), .acc(wr_acc), .recent(wr_recent),
    .last_addr(wr_last), .wbuf(wbuf), .wmask(wmask),
    .commit(wr_commit), .commit_addr(wr_caddr)
  );

  logic             rd_acc, rd_re, rd_fwd;
  logic [AW-1:0]    rd_raddr;
  logic [BEATS-1:0] rd_beat;

  b4_rd_ctrl #(.AW(AW)) u_rd (
    .clk(clk), .rst(rst), .main(main), .req_n(rd_n), .addr(rd_addr),
    .wr_recent(wr_recent), .wr_last(wr_last), .acc(rd_acc),
    .ram_re(rd_re), .ram_addr(rd_raddr), .beat(rd_beat), .fwd(rd_fwd)
  );

  wire [LANES*BYTE_W-1:0] rd_flat;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    b4_lane_ram #(.DEPTH(DEPTH), .BW(BYTE_W)) u_ram (
      .clk(clk),
      .we(wr_commit && wmask[l]),
      .waddr(wr_caddr),
      .wdata(wbuf[l*BYTE_W +: BYTE_W]),
      .re(rd_re),
      .raddr(rd_raddr),
      .rdata(rd_flat[l*BYTE_W +: BYTE_W])
    );
  end

  logic [WORD_W-1:0] nxt_q;

  always_comb begin
    nxt_q = '0;
    for (int k = 0; k < BEATS; k++) begin
      if (rd_beat[k]) begin
        for (int b = 0; b < BPW; b++) begin
          nxt_q[b*BYTE_W +: BYTE_W] =
            (rd_fwd && wmask[lane_idx(k, b, BPW)])
              ? wbuf[lane_idx(k, b, BPW)*BYTE_W +: BYTE_W]
              : rd_flat[lane_idx(k, b, BPW)*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      q_oe <= 1'b0;
    end else begin
      q    <= nxt_q;
      q_oe <= |rd_beat;
    end
  end

endmodule

// File: rtl/b4_checks.sv
module b4_checks #(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned BEATS  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              kphase,
  input logic              rd_acc,
  input logic              wr_acc,
  input logic [BEATS-1:0]  beat,
  input logic              commit,
  input logic              q_oe,
  input logic [WORD_W-1:0] q
);

  p_phase_alt_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> kphase != $past(kphase));

  p_main_only_r9: assert property (@(posedge clk) disable iff (rst)
    kphase |-> !(rd_acc || wr_acc));

  p_rd_gap_r4: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> ##1 !rd_acc);

  p_wr_gap_r4: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> ##1 !wr_acc);

  p_burst_start_r3: assert property (@(posedge clk) disable iff (rst)
    rd_acc |-> ##3 q_oe);

  p_one_beat_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(beat));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !q_oe |-> q == '0);

  p_commit_single_r5: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

endmodule

bind burst4_sram b4_checks #(.WORD_W(WORD_W), .BEATS(b4_pkg::BEATS)) u_chk (
  .clk(clk), .rst(rst), .kphase(kphase), .rd_acc(rd_acc), .wr_acc(wr_acc),
  .beat(rd_beat), .commit(wr_commit), .q_oe(q_oe), .q(q)
);

// File: tb/burst4_sram_tb.sv
module burst4_sram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSCEN = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  rd_addr = '0, wr_addr = '0;
  logic [17:0] d = '0;
  logic [1:0]  bw_n = 2'b00;
  logic [17:0] q;
  logic        q_oe, kphase;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst4_sram u_dut (
    .clk(clk), .rst(rst), .rd_n(rd_n), .rd_addr(rd_addr), .wr_n(wr_n),
    .wr_addr(wr_addr), .d(d), .bw_n(bw_n), .q(q), .q_oe(q_oe), .kphase(kphase)
  );

  // reference state
  logic [17:0] mm [8][4];
  int rq_t[$], rq_a[$], wq_t[$], wq_a[$];
  int last_r = -100, last_w = -100;
  logic [31:0] rng = 32'h1234_5677;

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    string tags [NSCEN];
    int    lens [NSCEN];
    int    e;
    logic  exp_oe;
    logic [17:0] exp_q;
    int    a_r, a_w, k;
    string tag;

    tags = '{"R5", "R3", "R4", "R6", "R7", "R9"};
    lens = '{48, 40, 80, 120, 160, 40};

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2", {31'd0, q_oe}, 32'd0);
    chk("R2", {14'd0, q}, 32'd0);
    chk("R2", {31'd0, kphase}, 32'd0);
    rst = 1'b0;

    e = 0;
    for (int s = 0; s < NSCEN; s++) begin
      for (int i = 0; i < lens[s]; i++) begin
        // stimulus for edge e
        rng = xs(rng);
        rd_n = 1'b1; wr_n = 1'b1; bw_n = 2'b00;
        a_r = int'(rng[2:0]); a_w = int'(rng[5:3]);
        d = rng[31:14];
        case (s)
          0: begin
            if (i % 4 == 0) begin wr_n = 1'b0; a_w = (i / 4) % 8; end
            if (i % 4 == 2 && i >= 10) begin rd_n = 1'b0; a_r = ((i - 10) / 4) % 8; end
          end
          1: if (i % 4 == 0) begin rd_n = 1'b0; a_r = (i / 4) % 8; end
          2: begin rd_n = rng[6]; wr_n = rng[7] & rng[8]; end
          3: begin rd_n = rng[6] & rng[7]; wr_n = rng[8] & rng[9]; bw_n = rng[11:10]; end
          4: begin
            rd_n = rng[6] & rng[7]; wr_n = rng[8] & rng[9]; bw_n = rng[11:10];
            a_r = int'(rng[12]); a_w = int'(rng[13]);
          end
          default: begin rd_n = ~e[0] | rng[6]; wr_n = ~e[0] | rng[7]; end
        endcase
        rd_addr = 8'(a_r); wr_addr = 8'(a_w);

        // model: output after edge e, before this edge's write capture
        exp_oe = 1'b0; exp_q = '0;
        foreach (rq_t[j]) begin
          if (e - rq_t[j] >= 2 && e - rq_t[j] <= 5) begin
            exp_oe = 1'b1;
            exp_q = mm[rq_a[j]][e - rq_t[j] - 2];
          end
        end
        foreach (wq_t[j]) begin
          if (e - wq_t[j] >= 2 && e - wq_t[j] <= 5) begin
            k = e - wq_t[j] - 2;
            if (!bw_n[0]) mm[wq_a[j]][k][8:0]  = d[8:0];
            if (!bw_n[1]) mm[wq_a[j]][k][17:9] = d[17:9];
          end
        end
        if (e % 2 == 0) begin
          if (!rd_n && last_r != e - 2) begin rq_t.push_back(e); rq_a.push_back(a_r); last_r = e; end
          if (!wr_n && last_w != e - 2) begin wq_t.push_back(e); wq_a.push_back(a_w); last_w = e; end
        end
        while (rq_t.size() > 0 && e - rq_t[0] > 5) begin void'(rq_t.pop_front()); void'(rq_a.pop_front()); end
        while (wq_t.size() > 0 && e - wq_t[0] > 5) begin void'(wq_t.pop_front()); void'(wq_a.pop_front()); end

        chk("R1", {31'd0, kphase}, {31'd0, e[0]});
        @(posedge clk);
        @(negedge clk);
        if (exp_oe) tag = tags[s];
        else if (s == 2 || s == 5) tag = tags[s];
        else tag = "R8";
        chk(tag, {31'd0, q_oe}, {31'd0, exp_oe});
        chk(tag, {14'd0, q}, {14'd0, exp_q});
        e++;
      end
    end

    rd_n = 1'b1; wr_n = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule